// File: doc/BRIEF.md
# Bus Command Strobe Sequencer

This block runs one legacy-style bus cycle at a time, clocked by the bus clock. A requester presents a cycle kind, a 24-bit address, one byte of write data, a DMA flag and a channel number. The block places the address (and, for ordinary writes, the data) on the bus one clock ahead of the command. It then pulls the chosen active-low command strobes low for a fixed number of clocks. At the end it returns any read byte together with a one-clock done pulse.

Two kinds of memory strobe are produced. The full-range pair works across the whole 16 MiB space. A second pair follows the same timing but is gated so that it only fires in the lowest megabyte. A slow target can pull the channel-ready input low to stretch the command by whole clocks. Once ready comes back, the command is held for one more clock before it ends. On DMA cycles the address names memory, the peripheral is chosen only by its acknowledge line, and a memory strobe and the opposite I/O strobe fire together.

Top module: `cmd_strobe_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, every command strobe and every acknowledge is high, `bus_doe` and `rsp_done` are low, and `req_ready` is high.
- R2: A request is taken only on a clock edge where `req_ready` is high. `req_ready` stays low from acceptance until the clock after the done pulse. Requests presented while busy are ignored, and `bus_addr` keeps the accepted address.
- R3: With ready held high, the cycle runs as follows. Strobes stay high for one setup clock after acceptance. The command is then low for exactly CMD_CYC clocks (default 2). `rsp_done` is high for the one clock after the strobes rise, and `req_ready` returns in the clock after that.
- R4: `req_kind` encodes 0 as memory read, 1 as memory write, 2 as I/O read and 3 as I/O write. A non-DMA memory read or write lowers `mem_rd_n` or `mem_wr_n` for any 24-bit address.
- R5: `lmem_rd_n` and `lmem_wr_n` go low together with `mem_rd_n` and `mem_wr_n` only when the address is at most 0x0FFFFF, that is when address bits 23:20 are all zero. Otherwise they stay high.
- R6: On a non-DMA write, `bus_doe` is high and `bus_dout` equals the write byte from the setup clock, before the strobe falls, through the done clock, after it rises.
- R7: On a non-DMA read, `rsp_data` takes `bus_din` as sampled on the edge at which the strobe rises, and is valid while `rsp_done` is high.
- R8: A DMA cycle works as follows. When `req_kind` bit 0 is 0, `mem_rd_n` and `io_wr_n` go low together. When it is 1, `mem_wr_n` and `io_rd_n` go low together. `dack_n[req_chan]` is low from the setup clock through the done clock. The data bus is not driven, and `rsp_data` is left unchanged.
- R9: Each clock on which `chan_rdy` is sampled low during the command adds one clock. The clock after it is sampled high again adds one more. A single run of W low samples therefore gives CMD_CYC+W+1 low clocks.
- R10: `chan_rdy` has no effect during the setup and done clocks.
- R11: A non-DMA cycle keeps every `dack_n` line high. I/O cycles leave all four memory strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Cycle kind (0 mem rd, 1 mem wr, 2 io rd, 3 io wr) |
| req_dma | input | 1 | DMA cycle flag |
| req_chan | input | 2 | DMA channel number |
| req_addr | input | 24 | Cycle address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle, request can be taken |
| chan_rdy | input | 1 | Channel ready, low stretches the command |
| bus_din | input | 8 | Data bus input |
| bus_addr | output | 24 | Driven address |
| bus_dout | output | 8 | Driven write data |
| bus_doe | output | 1 | Data bus drive enable |
| mem_rd_n | output | 1 | Full-range memory read strobe |
| mem_wr_n | output | 1 | Full-range memory write strobe |
| lmem_rd_n | output | 1 | Low-megabyte memory read strobe |
| lmem_wr_n | output | 1 | Low-megabyte memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| dack_n | output | 4 | Per-channel DMA acknowledge |
| rsp_data | output | 8 | Captured read byte |
| rsp_done | output | 1 | One-clock completion pulse |

## Verification
Take the accepting edge as E0. The address and drive enable are due after E0, and the strobes fall after E1. The strobes rise after edge E(1+L), where L is CMD_CYC or CMD_CYC+W+1, and `rsp_done` with the read byte arrives at that same edge. `req_ready` returns after E(2+L). The bench drives and samples at falling edges and walks these offsets one clock at a time, checking the strobe pattern on every command clock. This catches a strobe that ends one clock early or late.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  typedef enum logic [1:0] {
    K_MEM_RD = 2'd0,
    K_MEM_WR = 2'd1,
    K_IO_RD  = 2'd2,
    K_IO_WR  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_TAIL
  } phase_e;

  typedef struct packed {
    logic mrd;
    logic mwr;
    logic iord;
    logic iowr;
    logic lmrd;
    logic lmwr;
  } strb_t;
endpackage

// File: rtl/cmd_seq_decode.sv
module cmd_seq_decode
  import cmd_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 20
) (
  input  kind_e              kind,
  input  logic               dma,
  input  logic [ADDR_W-1:0]  addr,
  output strb_t              en,
  output logic               drive,
  output logic               capture
);
  logic lowm;

  generate
    if (LOW_W >= ADDR_W) begin : g_all_low
      assign lowm = 1'b1;
    end else begin : g_gate_low
      assign lowm = ~|addr[ADDR_W-1:LOW_W];
    end
  endgenerate

  always_comb begin
    en = '0;
    if (dma) begin
      // memory side direction comes from kind bit 0, I/O side is the opposite
      if (!kind[0]) begin
        en.mrd  = 1'b1;
        en.iowr = 1'b1;
      end else begin
        en.mwr  = 1'b1;
        en.iord = 1'b1;
      end
    end else begin
      unique case (kind)
        K_MEM_RD: en.mrd  = 1'b1;
        K_MEM_WR: en.mwr  = 1'b1;
        K_IO_RD:  en.iord = 1'b1;
        K_IO_WR:  en.iowr = 1'b1;
        default:  en = '0;
      endcase
    end
    en.lmrd = en.mrd & lowm;
    en.lmwr = en.mwr & lowm;
  end

  assign drive   = !dma && (kind == K_MEM_WR || kind == K_IO_WR);
  assign capture = !dma && (kind == K_MEM_RD || kind == K_IO_RD);
endmodule

// File: rtl/cmd_seq_timer.sv
module cmd_seq_timer
  import cmd_seq_pkg::*;
#(
  parameter int CMD_CYC = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   chan_rdy,
  output phase_e phase,
  output logic   go_cmd,
  output logic   end_cmd,
  output logic   end_tail
);
  localparam int CNT_W = (CMD_CYC > 1) ? $clog2(CMD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             stall;

  assign go_cmd   = (phase == ST_SETUP);
  assign end_cmd  = (phase == ST_CMD) && chan_rdy && !stall && (cnt == LAST);
  assign end_tail = (phase == ST_TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= ST_IDLE;
      cnt   <= '0;
      stall <= 1'b0;
    end else begin
      unique case (phase)
        ST_IDLE: begin
          if (start) phase <= ST_SETUP;
        end
        ST_SETUP: begin
          phase <= ST_CMD;
          cnt   <= '0;
          stall <= 1'b0;
        end
        ST_CMD: begin
          if (!chan_rdy) begin
            stall <= 1'b1;
          end else if (stall) begin
            stall <= 1'b0;
          end else if (cnt == LAST) begin
            phase <= ST_TAIL;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_TAIL: phase <= ST_IDLE;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assert_setup_to_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_SETUP) |=> (phase == ST_CMD));

  assert_stretch_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_CMD && !chan_rdy) |=> (phase == ST_CMD));

  assert_hold_after_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_CMD && chan_rdy && $past(phase == ST_CMD) && $past(!chan_rdy))
      |=> (phase == ST_CMD));

  assert_tail_one_clock_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_TAIL) |=> (phase == ST_IDLE));
endmodule

// File: rtl/cmd_seq_outreg.sv
module cmd_seq_outreg
  import cmd_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int NCH    = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              busy,
  input  logic              go_cmd,
  input  logic              end_cmd,
  input  logic              end_tail,
  input  logic              req_dma,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  strb_t             en,
  input  logic              drive,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output strb_t             strb_n,
  output logic [NCH-1:0]    dack_n,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_done
);
  strb_t en_q;
  logic  cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_dout <= '0;
      bus_doe  <= 1'b0;
      strb_n   <= '1;
      dack_n   <= '1;
      rsp_data <= '0;
      rsp_done <= 1'b0;
      en_q     <= '0;
      cap_q    <= 1'b0;
    end else begin
      rsp_done <= end_cmd;
      if (start) begin
        bus_addr <= req_addr;
        bus_dout <= req_wdata;
        bus_doe  <= drive;
        en_q     <= en;
        cap_q    <= capture;
        if (req_dma) dack_n <= ~(NCH'(1) << req_chan);
      end
      if (go_cmd) strb_n <= ~en_q;
      if (end_cmd) begin
        strb_n <= '1;
        if (cap_q) rsp_data <= bus_din;
      end
      if (end_tail) begin
        bus_doe <= 1'b0;
        dack_n  <= '1;
      end
    end
  end

  assert_lowmeg_rd_R5: assert property (@(posedge clk) disable iff (rst)
    !strb_n.lmrd |-> !strb_n.mrd);

  assert_lowmeg_wr_R5: assert property (@(posedge clk) disable iff (rst)
    !strb_n.lmwr |-> !strb_n.mwr);

  assert_io_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(!strb_n.iord && !strb_n.iowr));

  assert_dma_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
    (dack_n != '1) |-> !bus_doe);

  assert_dack_single_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dack_n));

  assert_wdata_before_R6: assert property (@(posedge clk) disable iff (rst)
    (($fell(strb_n.mwr) || $fell(strb_n.iowr)) && (dack_n == '1)) |-> $past(bus_doe));

  assert_wdata_after_R6: assert property (@(posedge clk) disable iff (rst)
    (($rose(strb_n.mwr) || $rose(strb_n.iowr)) && (dack_n == '1)) |-> bus_doe);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bus_addr));
endmodule

// File: rtl/cmd_strobe_seq.sv
module cmd_strobe_seq
  import cmd_seq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int LOW_W   = 20,
  parameter int NCH     = 4,
  parameter int CMD_CYC = 2,
  parameter int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_dma,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              chan_rdy,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              lmem_rd_n,
  output logic              lmem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic [NCH-1:0]    dack_n,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_done
);
  phase_e phase;
  logic   start, go_cmd, end_cmd, end_tail, busy;
  strb_t  en, strb_n;
  logic   drive, capture;

  assign req_ready = (phase == ST_IDLE);
  assign busy      = !req_ready;
  assign start     = req_valid && req_ready;

  cmd_seq_decode #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_dec (
    .kind    (kind_e'(req_kind)),
    .dma     (req_dma),
    .addr    (req_addr),
    .en      (en),
    .drive   (drive),
    .capture (capture)
  );

  cmd_seq_timer #(.CMD_CYC(CMD_CYC)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .chan_rdy (chan_rdy),
    .phase    (phase),
    .go_cmd   (go_cmd),
    .end_cmd  (end_cmd),
    .end_tail (end_tail)
  );

  cmd_seq_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .CH_W(CH_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .go_cmd    (go_cmd),
    .end_cmd   (end_cmd),
    .end_tail  (end_tail),
    .req_dma   (req_dma),
    .req_chan  (req_chan),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .en        (en),
    .drive     (drive),
    .capture   (capture),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .strb_n    (strb_n),
    .dack_n    (dack_n),
    .rsp_data  (rsp_data),
    .rsp_done  (rsp_done)
  );

  assign mem_rd_n  = strb_n.mrd;
  assign mem_wr_n  = strb_n.mwr;
  assign lmem_rd_n = strb_n.lmrd;
  assign lmem_wr_n = strb_n.lmwr;
  assign io_rd_n   = strb_n.iord;
  assign io_wr_n   = strb_n.iowr;

  assert_done_after_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_done) |-> $past(!mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n));

  assert_ready_after_done_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> req_ready);
endmodule

// File: tb/sim_cmd_strobe_seq.sv
`timescale 1ns/1ps
module sim_cmd_strobe_seq;
  localparam int CMD_CYC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_dma = 1'b0;
  logic [1:0]  req_chan = 2'd0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic        chan_rdy = 1'b1;
  logic [7:0]  bus_din = '0;
  logic [23:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_doe;
  logic        mem_rd_n, mem_wr_n, lmem_rd_n, lmem_wr_n, io_rd_n, io_wr_n;
  logic [3:0]  dack_n;
  logic [7:0]  rsp_data;
  logic        rsp_done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [7:0] last_rsp = 8'h00;

  always #4 clk = ~clk;

  cmd_strobe_seq #(.CMD_CYC(CMD_CYC)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_dma(req_dma), .req_chan(req_chan), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .chan_rdy(chan_rdy),
    .bus_din(bus_din), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .lmem_rd_n(lmem_rd_n), .lmem_wr_n(lmem_wr_n), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .dack_n(dack_n), .rsp_data(rsp_data), .rsp_done(rsp_done)
  );

  function automatic logic [5:0] strobes();
    return {~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n, ~lmem_rd_n, ~lmem_wr_n};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Runs one cycle; exp_en order {mrd,mwr,iord,iowr,lmrd,lmwr}
  task automatic run_cyc(input string req, input logic [1:0] kind, input bit dma,
                         input int chan, input logic [23:0] addr, input logic [7:0] wd,
                         input logic [7:0] din, input int w, input bit rdy_idle_low,
                         input bit poke, input logic [5:0] exp_en,
                         input bit exp_doe, input bit exp_cap);
    int L;
    logic [3:0] exp_dack;
    L = CMD_CYC + ((w > 0) ? w + 1 : 0);
    exp_dack = dma ? ~(4'b0001 << chan) : 4'hF;
    check("R2", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_kind = kind; req_dma = dma; req_chan = chan[1:0];
    req_addr = addr; req_wdata = wd; bus_din = din;
    @(posedge clk); @(negedge clk);
    // setup clock
    req_valid = poke;
    if (poke) begin req_addr = ~addr; req_kind = ~kind; end
    check("R3", "setup strobes high", {26'd0, strobes()}, 32'd0);
    check("R2", "setup address", {8'd0, bus_addr}, {8'd0, addr});
    check("R2", "busy in setup", {31'd0, req_ready}, 32'd0);
    check("R6", "doe in setup", {31'd0, bus_doe}, {31'd0, exp_doe});
    if (exp_doe) check("R6", "dout in setup", {24'd0, bus_dout}, {24'd0, wd});
    check(dma ? "R8" : "R11", "dack in setup", {28'd0, dack_n}, {28'd0, exp_dack});
    chan_rdy = rdy_idle_low ? 1'b0 : 1'b1;
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      chan_rdy = (i < w) ? 1'b0 : 1'b1;
      check((w > 0) ? "R9" : "R3", "command strobes", {26'd0, strobes()}, {26'd0, exp_en});
      check("R2", "address held", {8'd0, bus_addr}, {8'd0, addr});
      check("R6", "doe in command", {31'd0, bus_doe}, {31'd0, exp_doe});
      check(dma ? "R8" : "R11", "dack in command", {28'd0, dack_n}, {28'd0, exp_dack});
    end
    @(negedge clk);
    // done clock
    if (exp_cap) last_rsp = din;
    check((w > 0) ? "R9" : "R3", "strobes end", {26'd0, strobes()}, 32'd0);
    check("R7", "done pulse", {31'd0, rsp_done}, 32'd1);
    check(exp_cap ? "R7" : "R8", "read data", {24'd0, rsp_data}, {24'd0, last_rsp});
    check("R6", "doe hold", {31'd0, bus_doe}, {31'd0, exp_doe});
    if (exp_doe) check("R6", "dout hold", {24'd0, bus_dout}, {24'd0, wd});
    check(dma ? "R8" : "R11", "dack in done", {28'd0, dack_n}, {28'd0, exp_dack});
    if (rdy_idle_low) chan_rdy = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check("R3", "done single clock", {31'd0, rsp_done}, 32'd0);
    check("R2", "ready again", {31'd0, req_ready}, 32'd1);
    check("R6", "doe released", {31'd0, bus_doe}, 32'd0);
    check("R8", "dack released", {28'd0, dack_n}, 32'hF);
    chan_rdy = 1'b1;
  endtask

  task automatic t_reset();
    check("R1", "strobes", {26'd0, strobes()}, 32'd0);
    check("R1", "dack", {28'd0, dack_n}, 32'hF);
    check("R1", "doe", {31'd0, bus_doe}, 32'd0);
    check("R1", "done", {31'd0, rsp_done}, 32'd0);
    check("R1", "ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_mem_read_low();   // R4 R5 R7
    run_cyc("R4", 2'd0, 1'b0, 0, 24'h012345, 8'h00, 8'hA5, 0, 1'b0, 1'b0, 6'b100010, 1'b0, 1'b1);
  endtask
  task automatic t_mem_write_high(); // R4 R5 R6
    run_cyc("R5", 2'd1, 1'b0, 0, 24'h9ABCDE, 8'h3C, 8'h11, 0, 1'b0, 1'b0, 6'b010000, 1'b1, 1'b0);
  endtask
  task automatic t_lowmeg_edges();   // R5 boundary both sides
    run_cyc("R5", 2'd1, 1'b0, 0, 24'h0FFFFF, 8'h96, 8'h22, 0, 1'b0, 1'b0, 6'b010001, 1'b1, 1'b0);
    run_cyc("R5", 2'd0, 1'b0, 0, 24'h100000, 8'h00, 8'h6B, 0, 1'b0, 1'b0, 6'b100000, 1'b0, 1'b1);
  endtask
  task automatic t_io();             // R11 R7 R6
    run_cyc("R11", 2'd2, 1'b0, 0, 24'h0003F8, 8'h00, 8'h5A, 0, 1'b0, 1'b0, 6'b001000, 1'b0, 1'b1);
    run_cyc("R11", 2'd3, 1'b0, 0, 24'h000378, 8'hC3, 8'h33, 0, 1'b0, 1'b0, 6'b000100, 1'b1, 1'b0);
  endtask
  task automatic t_dma();            // R8
    run_cyc("R8", 2'd0, 1'b1, 2, 24'h045000, 8'hEE, 8'h44, 0, 1'b0, 1'b0, 6'b100110, 1'b0, 1'b0);
    run_cyc("R8", 2'd1, 1'b1, 1, 24'hF00000, 8'hEE, 8'h55, 0, 1'b0, 1'b0, 6'b011000, 1'b0, 1'b0);
  endtask
  task automatic t_wait();           // R9
    run_cyc("R9", 2'd0, 1'b0, 0, 24'h000400, 8'h00, 8'h7E, 3, 1'b0, 1'b0, 6'b100010, 1'b0, 1'b1);
    run_cyc("R9", 2'd3, 1'b0, 0, 24'h000080, 8'h81, 8'h00, 1, 1'b0, 1'b0, 6'b000100, 1'b1, 1'b0);
  endtask
  task automatic t_ready_ignored();  // R10
    run_cyc("R10", 2'd2, 1'b0, 0, 24'h000210, 8'h00, 8'hB4, 0, 1'b1, 1'b0, 6'b001000, 1'b0, 1'b1);
  endtask
  task automatic t_busy_poke();      // R2
    run_cyc("R2", 2'd1, 1'b0, 0, 24'h00C000, 8'h5F, 8'h00, 0, 1'b0, 1'b1, 6'b010001, 1'b1, 1'b0);
    @(negedge clk);
    check("R2", "poke not taken", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mem_read_low();
    t_mem_write_high();
    t_lowmeg_edges();
    t_io();
    t_dma();
    t_wait();
    t_ready_ignored();
    t_busy_poke();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule